// File: doc/BRIEF.md
# Edge-Latched Status Interrupt Controller

This block watches a set of live status conditions from a serial-bus controller's transfer engine and FIFOs, and folds them into one interrupt line. It does not act on levels. A cause bit is captured only when its status input moves from low to high. Software sees a cause that newly appeared. It does not see a condition that has simply stayed true.

Two registers are reachable through a plain single-cycle register port. The first is a mask register, which is read/write. The second is a cause register, which is write-one-to-clear. The interrupt output is the registered OR of all cause bits that are enabled by the mask. A driver typically handles the interrupt in three steps. First it clears the mask. Then it clears the causes it saw by writing them back. Finally it re-arms the mask for the next condition it waits on. A level that is already high when the mask is re-armed produces no new interrupt, so the driver must poll the live condition before it waits.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After reset the mask register reads all zeros, the cause register reads all zeros and `irq` is low.
- R2: A cause bit becomes 1 on the clock edge at which its status input is first sampled high after having been sampled low. A status input that stays high sets nothing further after its cause has been cleared.
- R3: A register write with `reg_sel`=1 clears every cause bit whose write-data bit is 1 and leaves the bits written 0 unchanged. Writing all ones clears every cause.
- R4: If a status rising edge and a clearing write to the same cause bit land on the same clock edge, the cause bit ends up set.
- R5: `irq` is a register. It is 1 in the cycle after a cycle in which some cause bit and its mask bit were both 1, and 0 otherwise.
- R6: The previous-status history resets to all ones. A status input that is already high when reset is released latches no cause until it has gone low and then high again.
- R7: `reg_sel`=0 selects the mask and `reg_sel`=1 selects the cause register, both for reads on `reg_rdata` (combinational) and for writes. A mask write stores the data exactly and does not change any cause. A cause write does not change the mask.
- R8: The status bit positions are fixed as follows:
  - bit 0: transfer done
  - bit 1: engine ready
  - bit 2: receive FIFO ready
  - bit 3: transmit FIFO ready
  - bit 4: receive FIFO empty
  - bit 5: receive FIFO full
  - bit 6: transmit FIFO empty
  - bit 7: transmit FIFO full
  - bits 8, 9, 10, 11: receive underflow, receive overflow, transmit underflow, transmit overflow
  - bit 12: address not configured

  Cause bit n records status bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| status | input | 13 | Live status conditions |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mask, 1 selects the cause register |
| reg_wdata | input | 13 | Write data; for the cause register a 1 clears that bit |
| reg_rdata | output | 13 | Contents of the selected register |
| irq | output | 1 | Registered interrupt request |

## Verification
Each bit is driven on its own through a rise, a held level, a clear, a fall and a second rise combined with a clear in the same cycle. This separates edge capture from level capture and shows the precedence of set over clear. A mask sweep enables one bit at a time, which exposes crossed mask-to-cause wiring and the one-cycle latency of `irq`. A reset with all status inputs high confirms that history starts at ones. A long pseudo-random run then mixes writes to both registers with toggling status and compares every cycle against an arithmetic model.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int NUM_SRC = 13;

  typedef enum logic {
    SEL_MASK  = 1'b0,
    SEL_CAUSE = 1'b1
  } reg_sel_e;

  localparam int BIT_XFER_DONE   = 0;
  localparam int BIT_XFER_READY  = 1;
  localparam int BIT_RX_READY    = 2;
  localparam int BIT_TX_READY    = 3;
  localparam int BIT_RX_EMPTY    = 4;
  localparam int BIT_RX_FULL     = 5;
  localparam int BIT_TX_EMPTY    = 6;
  localparam int BIT_TX_FULL     = 7;
  localparam int BIT_RX_UNDER    = 8;
  localparam int BIT_RX_OVER     = 9;
  localparam int BIT_TX_UNDER    = 10;
  localparam int BIT_TX_OVER     = 11;
  localparam int BIT_NO_ADDR_CFG = 12;
endpackage

// File: rtl/stat_edge_det.sv
module stat_edge_det #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  output logic [W-1:0] rise
);
  logic [W-1:0] hist_q;

  // History starts at ones so conditions already high out of reset are not edges.
  always_ff @(posedge clk) begin
    if (rst) hist_q <= '1;
    else     hist_q <= status;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign rise[g] = status[g] & ~hist_q[g];
    end
  endgenerate
endmodule

// File: rtl/cause_bank.sv
module cause_bank #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] clr,
  output logic [W-1:0] cause
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic bit_q;
      // A fresh edge takes precedence over a clear in the same cycle.
      always_ff @(posedge clk) begin
        if (rst)          bit_q <= 1'b0;
        else if (rise[g]) bit_q <= 1'b1;
        else if (clr[g])  bit_q <= 1'b0;
      end
      assign cause[g] = bit_q;
    end
  endgenerate
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cause,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] mask_q;
  logic         irq_q;
  logic [W-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_wr) mask_q <= wdata;
  end

  assign pend = cause & mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end

  assign mask = mask_q;
  assign irq  = irq_q;
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int W = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  input  logic         reg_wr,
  input  logic         reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq
);
  logic [W-1:0] rise;
  logic [W-1:0] clr_vec;
  logic [W-1:0] cause_q;
  logic [W-1:0] mask_q;
  logic         mask_wr;
  reg_sel_e     sel;

  assign sel     = reg_sel_e'(reg_sel);
  assign mask_wr = reg_wr && (sel == SEL_MASK);
  assign clr_vec = (reg_wr && (sel == SEL_CAUSE)) ? reg_wdata : '0;

  stat_edge_det #(.W(W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .rise   (rise)
  );

  cause_bank #(.W(W)) u_cause (
    .clk   (clk),
    .rst   (rst),
    .rise  (rise),
    .clr   (clr_vec),
    .cause (cause_q)
  );

  irq_gate #(.W(W)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .mask_wr (mask_wr),
    .wdata   (reg_wdata),
    .cause   (cause_q),
    .mask    (mask_q),
    .irq     (irq)
  );

  always_comb begin
    case (sel)
      SEL_MASK:  reg_rdata = mask_q;
      default:   reg_rdata = cause_q;
    endcase
  end
endmodule

// File: rtl/stat_irq_checker.sv
module stat_irq_checker #(
  parameter int W = 13
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] rise,
  input logic [W-1:0] clr_vec,
  input logic [W-1:0] cause_q,
  input logic [W-1:0] mask_q,
  input logic         mask_wr,
  input logic [W-1:0] reg_wdata,
  input logic         irq
);
  // R1: mask comes out of reset cleared
  assert_mask_reset_R1: assert property (@(posedge clk)
    rst |=> (mask_q == '0));

  // R2: a cause bit only turns on where the edge detector reported a rise
  assert_set_only_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & ~$past(cause_q) & ~$past(rise)) == '0));

  // R3: a cleared bit without a simultaneous rise is zero afterwards
  assert_clear_works_R3: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & $past(clr_vec) & ~$past(rise)) == '0));

  // R4: every reported rise is held in the cause register next cycle
  assert_edge_wins_R4: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & $past(rise)) == $past(rise)));

  // R5: interrupt follows the masked causes one cycle later
  assert_irq_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (irq == $past(|(cause_q & mask_q))));

  // R7: a mask write stores the data exactly
  assert_mask_store_R7: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_q == $past(reg_wdata)));
endmodule

bind stat_irq_ctrl stat_irq_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rise      (rise),
  .clr_vec   (clr_vec),
  .cause_q   (cause_q),
  .mask_q    (mask_q),
  .mask_wr   (mask_wr),
  .reg_wdata (reg_wdata),
  .irq       (irq)
);

// File: tb/stat_irq_ctrl_test.sv
module stat_irq_ctrl_test;
  localparam int W = 13;
  localparam int CLK_HALF = 5;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] status = '0;
  logic         reg_wr = 1'b0;
  logic         reg_sel = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         irq;

  int vecs = 0;
  int errs = 0;

  logic [W-1:0] m_prev = ONES;
  logic [W-1:0] m_cause = '0;
  logic [W-1:0] m_mask = '0;
  logic         m_irq = 1'b0;

  always #CLK_HALF clk = ~clk;

  stat_irq_ctrl uut (
    .clk       (clk),
    .rst       (rst),
    .status    (status),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    reg_wr  = 1'b0;
    reg_sel = 1'b1;
    #1 check(req, "cause", reg_rdata, m_cause);
    reg_sel = 1'b0;
    #1 check(req, "mask", reg_rdata, m_mask);
    check(req, "irq", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge, check after.
  task automatic step(input string req, input logic [W-1:0] st, input logic wr,
                      input logic sel, input logic [W-1:0] wd);
    logic [W-1:0] rs;
    logic [W-1:0] nxt_cause;
    status    = st;
    reg_wr    = wr;
    reg_sel   = sel;
    reg_wdata = wd;
    @(posedge clk);
    rs = st & ~m_prev;
    nxt_cause = m_cause;
    if (wr && sel) nxt_cause = nxt_cause & ~wd;
    nxt_cause = nxt_cause | rs;
    m_irq   = |(m_cause & m_mask);
    m_cause = nxt_cause;
    if (wr && !sel) m_mask = wd;
    m_prev  = st;
    @(negedge clk);
    check_all(req);
  endtask

  task automatic do_reset(input logic [W-1:0] st);
    rst = 1'b1;
    status = st;
    reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_prev = ONES; m_cause = '0; m_mask = '0; m_irq = 1'b0;
  endtask

  initial begin : watchdog
    #(2 * CLK_HALF * 150000);
    errs++;
    vecs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    logic [15:0] lf;
    @(negedge clk);
    // R1 reset state, then R6: inputs all high out of reset latch nothing
    do_reset(ONES);
    check_all("R1");
    step("R6", ONES, 1'b0, 1'b0, '0);
    step("R6", ONES, 1'b0, 1'b0, '0);
    check("R6", "no latch from high level", reg_rdata, '0);
    step("R6", '0, 1'b0, 1'b0, '0);
    step("R6", ONES, 1'b0, 1'b0, '0);
    step("R3", ONES, 1'b1, 1'b1, ONES);   // all-ones clear
    step("R3", '0, 1'b0, 1'b0, '0);

    // Per-bit sweep
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] b;
      b = '0; b[i] = 1'b1;
      step("R7", '0, 1'b1, 1'b0, b);             // mask only bit i
      step("R2", b, 1'b0, 1'b0, '0);             // rise sets cause
      step("R5", b, 1'b0, 1'b0, '0);             // irq one cycle later
      step("R3", b, 1'b1, 1'b1, ~b);             // clearing other bits does nothing
      step("R3", b, 1'b1, 1'b1, b);              // clear bit i
      step("R2", b, 1'b0, 1'b0, '0);             // held level: stays clear
      step("R5", b, 1'b1, 1'b0, ~b);             // cause elsewhere none: irq low
      step("R2", '0, 1'b1, 1'b0, b);
      step("R4", b, 1'b1, 1'b1, b);              // rise with clear: stays set
      step("R5", b, 1'b1, 1'b0, '0);             // mask off
      step("R7", '0, 1'b1, 1'b1, ONES);          // clear all causes
    end

    // R8 named positions: transfer done on bit 0, missing address config on bit 12
    step("R8", 13'h0001, 1'b0, 1'b0, '0);
    check("R8", "done at bit 0", reg_rdata, '0);
    reg_sel = 1'b1;
    #1 check("R8", "done cause bit 0", reg_rdata, 13'h0001);
    step("R8", 13'h1000, 1'b1, 1'b1, 13'h0001);
    reg_sel = 1'b1;
    #1 check("R8", "addr cfg cause bit 12", reg_rdata, 13'h1000);
    step("R8", '0, 1'b1, 1'b1, ONES);

    // Long mixed run against the model
    lf = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] st;
      logic [W-1:0] wd;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      st = lf[W-1:0] ^ W'(k);
      wd = {lf[2:0], lf[15:6]};
      step("R5", st, (k % 3) == 0, lf[4], wd);
    end

    // Reset mid-run returns to R1 state
    do_reset('0);
    check_all("R1");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule